// File: doc/BRIEF.md
# Flag-generating datapath ALU

This block is the arithmetic logic unit of a single-cycle processor datapath. It takes two operands and a 3-bit operation code. In the same cycle it returns a result and four status flags. Five operations are defined: addition, subtraction, and bitwise exclusive-or, inclusive-or and and. The flags report a zero result, a negative result, signed overflow and unsigned carry-out.

The unit has no clock and holds no state. The branch logic around it can subtract two register values and read the zero flag to test for equality. The carry-out flag serves unsigned comparisons. The overflow flag serves signed ones, and it is computed separately from the carry, because a carry out of the top bit is not an overflow in itself. The operand width is a parameter and defaults to 32.

Top module: `dp_alu`

## Requirements
- R1: With op_i = 3'b000 the result is (a_i + b_i) modulo 2^W, and carry_o is the bit carried out of the top result bit.
- R2: With op_i = 3'b001 the result is (a_i - b_i) modulo 2^W, formed as a_i + ~b_i + 1. carry_o is 1 exactly when a_i >= b_i as unsigned numbers.
- R3: With op_i = 3'b100 the result is a_i XOR b_i. With 3'b101 it is a_i OR b_i. With 3'b110 it is a_i AND b_i.
- R4: zero_o is 1 exactly when every result bit is 0. For subtraction this means exactly when a_i equals b_i.
- R5: sign_o equals the most significant bit of the result.
- R6: For add and subtract, ovf_o is 1 exactly when the two's-complement result of the operation on signed operands falls outside the range of W signed bits.
- R7: For the three bitwise operations, ovf_o and carry_o are both 0.
- R8: The codes 3'b010, 3'b011 and 3'b111 give a result of 0, with sign_o, ovf_o and carry_o all 0 and zero_o set to 1.
- R9: The unit is combinational. A change on any input appears on the outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand |
| b_i | input | W | Second operand (the subtrahend for subtraction) |
| op_i | input | 3 | Operation code |
| y_o | output | W | Result |
| zero_o | output | 1 | Result is all zeros |
| sign_o | output | 1 | Most significant result bit |
| ovf_o | output | 1 | Signed overflow of add or subtract |
| carry_o | output | 1 | Unsigned carry out of add or subtract |

## Verification
A 4-bit copy of the unit is driven with every operand pair under every operation code. The 32-bit unit gets directed corner cases and a pseudo-random sweep.

The corner cases cover the following failures:
- 0x7FFFFFFF + 1 catches an overflow flag that is wired to the carry, because this sum overflows with no carry.
- 0xFFFFFFFF + 1 catches the opposite mistake, because it carries out with no overflow, and it also tests the zero flag.
- 0x80000000 - 1 catches an overflow check that forgets to invert the subtrahend's sign.
- Subtraction with equal operands catches a carry that is not inverted for subtraction, and a zero flag that would break equality branches.
- The unused codes catch a decoder that aliases them onto a live operation.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    ALU_ADD = 3'b000,
    ALU_SUB = 3'b001,
    ALU_XOR = 3'b100,
    ALU_OR  = 3'b101,
    ALU_AND = 3'b110
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  // sum of two operands plus a carry-in, one extra bit for the carry-out
  function automatic logic [W:0] add_cin(input logic [W-1:0] x,
                                         input logic [W-1:0] y,
                                         input logic cin);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  endfunction

  logic [W-1:0] b_eff;
  logic [W:0]   raw;

  assign b_eff  = sub_i ? ~b_i : b_i;
  assign raw    = add_cin(a_i, b_eff, sub_i);
  assign sum_o  = raw[W-1:0];
  assign cout_o = raw[W];
  // the effective operands agree in sign but the sum does not
  assign ovf_o  = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   fn_i,
  output logic [W-1:0] y_o
);
  // fn_i: 00 xor, 01 or, 10 and, 11 none
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      case (fn_i)
        2'b00:   y_o[i] = a_i[i] ^ b_i[i];
        2'b01:   y_o[i] = a_i[i] | b_i[i];
        2'b10:   y_o[i] = a_i[i] & b_i[i];
        default: y_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] y_i,
  output logic         zero_o,
  output logic         sign_o
);
  assign zero_o = ~|y_i;
  assign sign_o = y_i[W-1];
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    y_o,
  output logic            zero_o,
  output logic            sign_o,
  output logic            ovf_o,
  output logic            carry_o
);
  logic         arith_sel;
  logic         logic_sel;
  logic         sub_sel;
  logic [W-1:0] arith_y;
  logic [W-1:0] logic_y;
  logic         arith_cout;
  logic         arith_ovf;

  assign sub_sel   = (op_i == ALU_SUB);
  assign arith_sel = (op_i == ALU_ADD) || sub_sel;
  assign logic_sel = op_i[2] && (op_i[1:0] != 2'b11);

  alu_addsub #(.W(W)) u_addsub (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (sub_sel),
    .sum_o  (arith_y),
    .cout_o (arith_cout),
    .ovf_o  (arith_ovf)
  );

  alu_logic #(.W(W)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .fn_i (op_i[1:0]),
    .y_o  (logic_y)
  );

  always_comb begin
    if (arith_sel)      y_o = arith_y;
    else if (logic_sel) y_o = logic_y;
    else                y_o = '0;
  end

  assign carry_o = arith_sel & arith_cout;
  assign ovf_o   = arith_sel & arith_ovf;

  alu_flags #(.W(W)) u_flags (
    .y_i    (y_o),
    .zero_o (zero_o),
    .sign_o (sign_o)
  );
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] y_o,
  input logic         zero_o,
  input logic         sign_o,
  input logic         ovf_o,
  input logic         carry_o
);
  logic [W:0] wide_sum;
  logic [W:0] ext_sum;
  logic [W:0] ext_dif;

  assign wide_sum = {1'b0, a_i} + {1'b0, b_i};
  assign ext_sum  = {a_i[W-1], a_i} + {b_i[W-1], b_i};
  assign ext_dif  = {a_i[W-1], a_i} - {b_i[W-1], b_i};

  always_comb begin
    if (op_i == 3'b000) begin
      // R1
      add_carry_chk: assert (carry_o == wide_sum[W]);
      // R4
      add_zero_chk: assert (zero_o == (wide_sum[W-1:0] == '0));
      // R6
      add_ovf_chk: assert (ovf_o == (ext_sum[W] != ext_sum[W-1]));
    end
    if (op_i == 3'b001) begin
      // R2
      sub_carry_chk: assert (carry_o == (a_i >= b_i));
      // R4
      sub_zero_chk: assert (zero_o == (a_i == b_i));
      // R6
      sub_ovf_chk: assert (ovf_o == (ext_dif[W] != ext_dif[W-1]));
    end
    if (op_i[2] && op_i[1:0] != 2'b11) begin
      // R7
      logic_no_flags_chk: assert (!ovf_o && !carry_o);
    end
    if (op_i == 3'b110) begin
      // R5
      and_sign_chk: assert (sign_o == (a_i[W-1] & b_i[W-1]));
    end
    if (op_i == 3'b101) begin
      // R3
      or_cover_chk: assert ((y_o & a_i) == a_i);
    end
    if (op_i == 3'b010 || op_i == 3'b011 || op_i == 3'b111) begin
      // R8
      unused_code_chk: assert (y_o == '0 && zero_o && !sign_o && !ovf_o && !carry_o);
    end
  end
endmodule

bind dp_alu dp_alu_chk #(.W(W)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .op_i    (op_i),
  .y_o     (y_o),
  .zero_o  (zero_o),
  .sign_o  (sign_o),
  .ovf_o   (ovf_o),
  .carry_o (carry_o)
);

// File: tb/dp_alu_bench.sv
module dp_alu_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] a32 = '0, b32 = '0;
  logic [2:0]  op32 = 3'b000;
  logic [31:0] y32;
  logic        z32, s32, v32, c32;

  logic [3:0]  a4 = '0, b4 = '0;
  logic [2:0]  op4 = 3'b000;
  logic [3:0]  y4;
  logic        z4, s4, v4, c4;

  dp_alu #(.W(32)) u_dp_alu (
    .a_i(a32), .b_i(b32), .op_i(op32), .y_o(y32),
    .zero_o(z32), .sign_o(s32), .ovf_o(v32), .carry_o(c32)
  );

  dp_alu #(.W(4)) u_dp_alu_w4 (
    .a_i(a4), .b_i(b4), .op_i(op4), .y_o(y4),
    .zero_o(z4), .sign_o(s4), .ovf_o(v4), .carry_o(c4)
  );

  function automatic longint to_signed(int w, longint v);
    if (v >= (longint'(1) << (w - 1))) return v - (longint'(1) << w);
    return v;
  endfunction

  function automatic bit out_of_range(int w, longint s);
    longint hi = (longint'(1) << (w - 1)) - 1;
    longint lo = -(longint'(1) << (w - 1));
    return (s > hi) || (s < lo);
  endfunction

  task automatic one(input string tag, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic verify(input int w, input logic [2:0] op, input longint a, input longint b,
                        input longint res, input logic z, input logic s,
                        input logic v, input logic c);
    longint mask = (longint'(1) << w) - 1;
    longint er = 0;
    logic ev = 0, ec = 0, ez, es;
    string rtag;
    case (op)
      3'b000: begin
        er = (a + b) & mask;
        ec = ((a + b) >> w) != 0;
        ev = out_of_range(w, to_signed(w, a) + to_signed(w, b));
        rtag = "R1";
      end
      3'b001: begin
        er = (a - b) & mask;
        ec = (a >= b);
        ev = out_of_range(w, to_signed(w, a) - to_signed(w, b));
        rtag = "R2";
      end
      3'b100: begin er = a ^ b; rtag = "R3"; end
      3'b101: begin er = a | b; rtag = "R3"; end
      3'b110: begin er = a & b; rtag = "R3"; end
      default: begin er = 0; rtag = "R8"; end
    endcase
    ez = (er == 0);
    es = ((er >> (w - 1)) & 1) != 0;
    one({rtag, " result"}, res == er, res, er);
    one("R4 zero", z == ez, longint'(z), longint'(ez));
    one("R5 sign", s == es, longint'(s), longint'(es));
    if (op == 3'b000 || op == 3'b001) begin
      one({rtag, " R6 overflow"}, v == ev, longint'(v), longint'(ev));
      one({rtag, " carry"}, c == ec, longint'(c), longint'(ec));
    end else begin
      one({(rtag == "R8") ? "R8" : "R7", " overflow"}, v == 1'b0, longint'(v), 0);
      one({(rtag == "R8") ? "R8" : "R7", " carry"}, c == 1'b0, longint'(c), 0);
    end
  endtask

  task automatic run32(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op32 = op; a32 = a; b32 = b;
    #2;
    verify(32, op, longint'(a), longint'(b), longint'(y32), z32, s32, v32, c32);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #10000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] x;
    // reset-free state: inputs at zero give an add of 0+0
    #2;
    verify(32, 3'b000, 0, 0, longint'(y32), z32, s32, v32, c32);

    // R1 / R6: positive overflow with no carry
    run32(3'b000, 32'h7FFF_FFFF, 32'h0000_0001);
    // R1 / R4: carry and zero with no overflow
    run32(3'b000, 32'hFFFF_FFFF, 32'h0000_0001);
    run32(3'b000, 32'h8000_0000, 32'h8000_0000);
    // R2 / R6: negative minus one overflows
    run32(3'b001, 32'h8000_0000, 32'h0000_0001);
    // R2 / R4: equal operands
    run32(3'b001, 32'h1234_5678, 32'h1234_5678);
    run32(3'b001, 32'h0000_0000, 32'h0000_0000);
    run32(3'b001, 32'h0000_0001, 32'h0000_0002);
    // R3 / R7
    run32(3'b100, 32'hF0F0_A5A5, 32'hFF00_5A5A);
    run32(3'b101, 32'h8000_0000, 32'h0000_0001);
    run32(3'b110, 32'hFFFF_FFFF, 32'h8000_0001);
    // R8: unused codes
    run32(3'b010, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run32(3'b011, 32'h7FFF_FFFF, 32'h0000_0001);
    run32(3'b111, 32'h8000_0000, 32'h8000_0000);

    // R9: input change in mid cycle, seen before any clock edge
    @(posedge clk);
    #3;
    op32 = 3'b000; a32 = 32'h0000_0005; b32 = 32'h0000_0007;
    #1;
    one("R9 mid-cycle result", y32 == 32'h0000_000C, longint'(y32), 64'hC);

    // 32-bit pseudo-random sweep over every code
    x = 32'h2545_F491;
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ra, rb;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      ra = x;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      rb = (k % 5 == 0) ? ra : x;
      run32(3'(k % 8), ra, rb);
    end

    // exhaustive sweep of the 4-bit unit
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          @(negedge clk);
          op4 = 3'(op); a4 = 4'(a); b4 = 4'(b);
          #2;
          verify(4, 3'(op), longint'(a), longint'(b), longint'(y4), z4, s4, v4, c4);
        end
      end
    end

    finish_run();
  end
endmodule